// File: doc/BRIEF.md
# Temperature-Aware SDRAM Refresh Scheduler

This block paces refresh commands for a DDR3-class memory controller. A free-running cycle counter produces one refresh obligation per programmed interval. Software sets that interval to the retention window divided by 8192, counted in controller clocks. While the `hot` input is high, the interval is halved, because above 85 °C the device loses charge twice as fast. Obligations build up in a debt counter capped at eight, so the command arbiter may postpone refreshes while it serves traffic. An urgent flag tells the arbiter when the cap is reached.

A refresh may be issued only when every bank is closed. While debt is outstanding and the controller reports open banks, the block asks for a precharge of all banks. Once the banks are closed, it raises its refresh request instead. Each refresh grant taken while the refresh request is high retires one unit of debt. The request stays up until the debt is zero.

A self-refresh request is honoured only once no debt is outstanding. During self-refresh the interval counter is frozen and no requests are made. On exit the counter starts again from zero and one refresh is owed at once.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ref_req`, `pre_req`, `urgent` and `sr_active` are low and `pending_cnt` is 0.
- R2: With `hot` low and no grants, `pending_cnt` rises by one every `cfg_interval` cycles, counting from the release of reset. A `cfg_interval` of 0 acts as 1.
- R3: With `hot` high, the interval is `cfg_interval` shifted right by one (rounded down in the default build), with a minimum of 1.
- R4: While `pending_cnt` is non-zero and `sr_active` is low, `pre_req` follows `banks_open` and `ref_req` follows its inverse. The two are never high together, and both are low when `pending_cnt` is 0.
- R5: A cycle with `ref_gnt` and `ref_req` both high lowers `pending_cnt` by one. `ref_gnt` while `ref_req` is low has no effect. A grant in the same cycle as an interval expiry leaves `pending_cnt` unchanged.
- R6: `pending_cnt` saturates at MAX_DEBT (8); further expiries are dropped. `urgent` is high exactly when `pending_cnt` equals MAX_DEBT.
- R7: When `sr_req` is high and `pending_cnt` is 0, `sr_active` rises at the next edge. While it is high, `pending_cnt` stays 0, both requests stay low and the interval counter holds.
- R8: When `sr_req` falls during self-refresh, `sr_active` drops at the next edge with `pending_cnt` set to 1. The next expiry then comes a full interval later.
- R9: While `pending_cnt` is non-zero, `sr_req` does not start self-refresh. Entry follows at the edge after the debt reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | IW | Cycles per refresh at normal temperature |
| hot | input | 1 | High when the device is in the extended temperature range |
| banks_open | input | 1 | High while any bank is active |
| ref_gnt | input | 1 | Arbiter accepts the refresh request this cycle |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| ref_req | output | 1 | Refresh request to the arbiter |
| pre_req | output | 1 | Request to close all banks ahead of a refresh |
| urgent | output | 1 | Postponement limit reached |
| pending_cnt | output | DW | Number of refreshes owed |
| sr_active | output | 1 | Self-refresh in progress |

## Verification
The embedded properties assume that the arbiter grants only on cycles where it sees a request, but the design does not rely on this. They also assume `sr_req` is a level held across cycles and that `banks_open` comes from a register in the controller. The bench therefore drives every input one time unit after a rising edge and holds it for whole cycles. It deliberately raises `ref_gnt` while only `pre_req` is high, to exercise the ignore path. It changes `cfg_interval` and `hot` only when the counter has just wrapped or is held in reset, so every expected expiry cycle can be worked out from the requirements.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   typedef enum logic {
      MODE_RUN  = 1'b0,
      MODE_SELF = 1'b1
   } mode_e;

   function automatic int debt_width(input int max_debt);
      return (max_debt < 2) ? 1 : $clog2(max_debt + 1);
   endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
   parameter int IW       = 16,
   parameter bit ROUND_UP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          freeze,
   input  logic          restart,
   input  logic          hot,
   input  logic [IW-1:0] cfg_interval,
   output logic          tick
);

   localparam logic [IW-1:0] ONE = IW'(1);

   logic [IW-1:0] cnt_q;
   logic [IW-1:0] half_lim;
   logic [IW-1:0] raw_lim;
   logic [IW-1:0] lim;
   logic          at_end;

   if (IW < 2) begin : g_bad_width
      $error("refsched_timer: IW must be at least 2");
   end

   if (ROUND_UP) begin : g_half_up
      assign half_lim = (cfg_interval >> 1) + IW'(cfg_interval[0]);
   end else begin : g_half_down
      assign half_lim = cfg_interval >> 1;
   end

   always_comb begin
      raw_lim = hot ? half_lim : cfg_interval;
      lim     = (raw_lim == '0) ? ONE : raw_lim;
   end

   // a shortened limit after a switch to hot must still wrap at once
   assign at_end = (cnt_q >= (lim - ONE));
   assign tick   = !freeze && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (freeze)  cnt_q <= cnt_q;
      else if (at_end)  cnt_q <= '0;
      else              cnt_q <= cnt_q + ONE;
   end

   assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !restart) |=> (cnt_q == $past(cnt_q)));

   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
   parameter int MAX_DEBT = 8,
   parameter int DW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic          clear,
   input  logic          load_one,
   output logic [DW-1:0] debt,
   output logic          urgent,
   output logic          empty
);

   localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);
   localparam logic [DW-1:0] ONE = DW'(1);

   logic [DW-1:0] debt_q;

   if (MAX_DEBT < 1) begin : g_bad_cap
      $error("refsched_debt: MAX_DEBT must be at least 1");
   end
   if ((1 << DW) <= MAX_DEBT) begin : g_bad_dw
      $error("refsched_debt: DW too narrow for MAX_DEBT");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        debt_q <= '0;
      else if (clear)    debt_q <= '0;
      else if (load_one) debt_q <= ONE;
      else begin
         unique case ({inc, dec})
            2'b10:   if (debt_q != CAP) debt_q <= debt_q + ONE;
            2'b01:   if (debt_q != '0)  debt_q <= debt_q - ONE;
            default: debt_q <= debt_q;
         endcase
      end
   end

   assign debt   = debt_q;
   assign urgent = (debt_q == CAP);
   assign empty  = (debt_q == '0);

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      debt_q <= CAP);

   assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((int'(debt_q) - int'($past(debt_q)) <= 1) &&
                (int'($past(debt_q)) - int'(debt_q) <= 1)));

   assert_grant_retires_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !clear && !load_one && !empty) |=> (debt_q == $past(debt_q) - ONE));

endmodule

// File: rtl/refsched_mode.sv
module refsched_mode
   import refsched_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sr_req,
   input  logic debt_empty,
   output logic enter,
   output logic leave,
   output logic active
);

   mode_e mode_q;

   assign active = (mode_q == MODE_SELF);
   assign enter  = !active && sr_req && debt_empty;
   assign leave  = active && !sr_req;

   always_ff @(posedge clk) begin
      if (!rst_n)     mode_q <= MODE_RUN;
      else if (enter) mode_q <= MODE_SELF;
      else if (leave) mode_q <= MODE_RUN;
   end

   assert_entry_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(debt_empty));

   assert_exit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> !$past(sr_req));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refsched_pkg::*;
#(
   parameter int IW       = 16,
   parameter int MAX_DEBT = 8,
   parameter bit ROUND_UP = 1'b0,
   localparam int DW      = debt_width(MAX_DEBT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] cfg_interval,
   input  logic          hot,
   input  logic          banks_open,
   input  logic          ref_gnt,
   input  logic          sr_req,
   output logic          ref_req,
   output logic          pre_req,
   output logic          urgent,
   output logic [DW-1:0] pending_cnt,
   output logic          sr_active
);

   logic tick;
   logic enter;
   logic leave;
   logic debt_empty;
   logic want;
   logic retire;

   refsched_mode u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .sr_req     (sr_req),
      .debt_empty (debt_empty),
      .enter      (enter),
      .leave      (leave),
      .active     (sr_active)
   );

   refsched_timer #(.IW(IW), .ROUND_UP(ROUND_UP)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .freeze       (sr_active),
      .restart      (leave),
      .hot          (hot),
      .cfg_interval (cfg_interval),
      .tick         (tick)
   );

   refsched_debt #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (tick),
      .dec      (retire),
      .clear    (enter),
      .load_one (leave),
      .debt     (pending_cnt),
      .urgent   (urgent),
      .empty    (debt_empty)
   );

   assign want    = !sr_active && !debt_empty;
   assign pre_req = want && banks_open;
   assign ref_req = want && !banks_open;
   assign retire  = ref_req && ref_gnt;

   assert_one_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ref_req && pre_req));

   assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sr_active |-> (pending_cnt == '0 && !ref_req && !pre_req));

   assert_exit_owes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_active) |-> (pending_cnt == DW'(1)));

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_cnt == '0) |-> (!ref_req && !pre_req));

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;

   localparam int IW = 16;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] cfg_interval = 16'd1000;
   logic          hot = 1'b0;
   logic          banks_open = 1'b0;
   logic          ref_gnt = 1'b0;
   logic          sr_req = 1'b0;
   logic          ref_req;
   logic          pre_req;
   logic          urgent;
   logic [DW-1:0] pending_cnt;
   logic          sr_active;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   refresh_sched uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_interval (cfg_interval),
      .hot          (hot),
      .banks_open   (banks_open),
      .ref_gnt      (ref_gnt),
      .sr_req       (sr_req),
      .ref_req      (ref_req),
      .pre_req      (pre_req),
      .urgent       (urgent),
      .pending_cnt  (pending_cnt),
      .sr_active    (sr_active)
   );

   // hot, cfg_interval, expected cycles to first expiry
   localparam int NVEC = 7;
   localparam int VEC [NVEC][3] = '{
      '{0, 10, 10}, '{1, 10, 5}, '{0, 7, 7}, '{1, 7, 3},
      '{0, 2, 2},   '{1, 3, 1},  '{0, 0, 1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ref_gnt = 1'b0;
      sr_req = 1'b0;
      step(3);
      rst_n = 1'b1;
   endtask

   initial begin
      #(100000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // interval table, R2 (normal) and R3 (hot)
      for (int v = 0; v < NVEC; v++) begin
         int n;
         hot = VEC[v][0][0];
         cfg_interval = IW'(VEC[v][1]);
         banks_open = 1'b0;
         do_reset();
         n = 0;
         while (pending_cnt == '0 && n < 5000) begin
            step(1);
            n++;
         end
         chk((VEC[v][0] != 0) ? "R3 hot interval" : "R2 normal interval", n, VEC[v][2]);
      end

      // reset state and self-refresh sequence
      hot = 1'b0;
      cfg_interval = 16'd1000;
      do_reset();
      chk("R1 ref_req", int'(ref_req), 0);
      chk("R1 pre_req", int'(pre_req), 0);
      chk("R1 urgent", int'(urgent), 0);
      chk("R1 sr_active", int'(sr_active), 0);
      chk("R1 pending", int'(pending_cnt), 0);

      sr_req = 1'b1;
      step(1);
      chk("R7 entry", int'(sr_active), 1);
      step(1500);
      chk("R7 no debt in self-refresh", int'(pending_cnt), 0);
      chk("R7 no refresh request", int'(ref_req), 0);
      chk("R7 no precharge request", int'(pre_req), 0);

      sr_req = 1'b0;
      step(1);
      chk("R8 exit", int'(sr_active), 0);
      chk("R8 one refresh owed", int'(pending_cnt), 1);
      chk("R8 request raised", int'(ref_req), 1);
      begin
         int n = 0;
         while (pending_cnt == DW'(1) && n < 5000) begin
            step(1);
            n++;
         end
         chk("R8 counter restarted", n, 1000);
      end
      chk("R2 debt accumulates", int'(pending_cnt), 2);

      // precharge before refresh
      banks_open = 1'b1;
      #1;
      chk("R4 pre_req with open banks", int'(pre_req), 1);
      chk("R4 ref_req held back", int'(ref_req), 0);
      ref_gnt = 1'b1;
      step(1);
      ref_gnt = 1'b0;
      chk("R5 grant ignored without request", int'(pending_cnt), 2);
      banks_open = 1'b0;
      #1;
      chk("R4 ref_req once closed", int'(ref_req), 1);
      chk("R4 pre_req dropped", int'(pre_req), 0);
      ref_gnt = 1'b1;
      step(1);
      chk("R5 grant retires one", int'(pending_cnt), 1);
      step(1);
      ref_gnt = 1'b0;
      chk("R5 debt drained", int'(pending_cnt), 0);
      chk("R5 request released", int'(ref_req), 0);
      chk("R4 no precharge at zero debt", int'(pre_req), 0);

      // saturation: one expiry per cycle
      cfg_interval = 16'd2;
      hot = 1'b1;
      do_reset();
      step(1);
      chk("R3 minimum interval", int'(pending_cnt), 1);
      step(2);
      chk("R2 per-cycle expiries", int'(pending_cnt), 3);
      ref_gnt = 1'b1;
      step(2);
      ref_gnt = 1'b0;
      chk("R5 grant with expiry keeps debt", int'(pending_cnt), 3);
      step(4);
      chk("R6 below cap", int'(pending_cnt), 7);
      chk("R6 urgent low below cap", int'(urgent), 0);
      step(1);
      chk("R6 at cap", int'(pending_cnt), 8);
      chk("R6 urgent at cap", int'(urgent), 1);
      step(5);
      chk("R6 saturated", int'(pending_cnt), 8);

      cfg_interval = 16'd1000;
      hot = 1'b0;
      ref_gnt = 1'b1;
      step(1);
      ref_gnt = 1'b0;
      chk("R6 leaves cap on grant", int'(pending_cnt), 7);
      chk("R6 urgent clears", int'(urgent), 0);

      // self-refresh deferred while debt is owed
      sr_req = 1'b1;
      step(2);
      chk("R9 entry deferred", int'(sr_active), 0);
      ref_gnt = 1'b1;
      step(7);
      ref_gnt = 1'b0;
      chk("R9 debt drained", int'(pending_cnt), 0);
      chk("R9 still not in self-refresh", int'(sr_active), 0);
      step(1);
      chk("R9 entry after drain", int'(sr_active), 1);
      sr_req = 1'b0;
      step(1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule